// File: doc/BRIEF.md
# Addressable LED Stream Pixel Decoder

This block listens to the single data wire of a chain of addressable colour LEDs and turns the pulse train back into pixel colour words. Each bit starts with a rising edge. The length of its high phase, compared with the full bit period, gives the bit value. A low level that lasts longer than the reset interval ends a frame. Bits arrive most significant bit first and are packed into 24-bit three-channel words or 32-bit four-channel words. Each word is put back in channel order and presented with a one-cycle strobe.

All timing is counted in cycles of the system clock. Thresholds are derived from the `CLK_HZ` and `RESET_NS` parameters. The `mode` input selects the number of channels. The `bit_valid`/`bit_value` pair exposes every decoded bit for debug.

Top module: `pixel_stream_decoder`

## Requirements
- R1: A bit is decided at the rising edge that follows it. It is 1 when its high time is strictly more than half of the rise-to-rise period, and 0 otherwise (for example, 60 high in 120 gives 0 and 61 high in 120 gives 1). Each decision gives a one-cycle `bit_valid` pulse with `bit_value`.
- R2: The final bit before a frame reset has no closing rising edge. When an earlier bit exists in the same frame, that final bit is 1 if twice its high time is at least the previous bit's period.
- R3: When the final bit before a reset is the only bit of its frame, it is 1 if its high time is at least 625 ns in clock cycles (62 cycles at 100 MHz).
- R4: A low level lasting `RESET_NS` after a falling edge gives a one-cycle `frame_reset` pulse. Any final bit is emitted on `bit_valid` in the cycle before that pulse. The reset discards a partially collected pixel, so the next pixel starts from an empty accumulator.
- R5: After reset, all outputs are 0. A line that is high from reset produces no bit and no frame reset until it has first been seen low.
- R6: With `mode`=0, 24 bits make a pixel. The wire word (first byte green, then red, then blue) is output as `pixel_data` = {8'h00, red, green, blue}.
- R7: With `mode`=1, 32 bits make a pixel. The output is the wire word with bits [23:16] and [15:8] exchanged, while bits [31:24] and [7:0] stay in place.
- R8: `pixel_valid` pulses for one cycle, one cycle after the `bit_valid` of the 24th or 32nd bit. The accumulator then restarts, so back-to-back pixels in one frame decode independently.
- R9: A bit whose rise-to-rise time reaches the saturating counter limit (2^CW-1 cycles) is dropped, so a line stuck high produces no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Asynchronous LED data line |
| mode | input | 1 | 0: three channels (24 bits), 1: four channels (32 bits) |
| pixel_data | output | 32 | Reordered pixel word |
| pixel_valid | output | 1 | One-cycle strobe for `pixel_data` |
| frame_reset | output | 1 | One-cycle strobe on a frame reset |
| bit_valid | output | 1 | One-cycle strobe for each decoded bit |
| bit_value | output | 1 | Value of the decoded bit |

## Verification
A corrupted period or high-time counter shows up as a wrong `bit_value` one cycle after the closing rising edge. The exact-half and 625 ns boundary frames expose it within a single bit. A stale bit count or accumulator after a reset shows up as a missing or shifted pixel word on the first `pixel_valid` of the next frame. A wrong reset counter moves the `frame_reset` pulse outside its window, or leaves the final bit without its strobe one cycle earlier. A wrongly armed synchroniser gives bits or resets on a line that is held high from reset.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

    typedef enum logic {
        PX_RGB  = 1'b0,
        PX_RGBW = 1'b1
    } px_mode_e;

    typedef struct packed {
        logic valid;
        logic value;
    } bit_evt_t;

    localparam int unsigned PX_W = 32;

    // bits per pixel for a channel mode
    function automatic logic [5:0] px_need(px_mode_e m);
        return (m == PX_RGBW) ? 6'd32 : 6'd24;
    endfunction

    // exchange the two middle bytes; clear the top byte in 3-channel mode
    function automatic logic [PX_W-1:0] px_reorder(logic [PX_W-1:0] w, px_mode_e m);
        logic [7:0] top;
        top = (m == PX_RGBW) ? w[31:24] : 8'h00;
        return {top, w[15:8], w[23:16], w[7:0]};
    endfunction

endpackage

// File: rtl/pxd_line_sync.sv
module pxd_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic s1, s2, prev;

    // reset to the high level: no edge is seen until the line has been low
    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            prev <= 1'b1;
        end else begin
            s1   <= din;
            s2   <= s1;
            prev <= s2;
        end
    end

    assign level = s2;
    assign rise  = s2 & ~prev;
    assign fall  = ~s2 & prev;
endmodule

// File: rtl/pxd_bit_timer.sv
module pxd_bit_timer
    import pxd_pkg::*;
#(
    parameter int CW           = 14,
    parameter int RESET_CYC    = 5000,
    parameter int FALLBACK_CYC = 62
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     level,
    input  logic     rise,
    input  logic     fall,
    output bit_evt_t evt,
    output logic     frame_rst
);
    localparam logic [CW-1:0] CMAX = '1;

    logic          in_bit, have_fall, rst_armed, prev_ok, rst_d;
    logic [CW-1:0] per_cnt, hi_len, prev_per, low_cnt;
    logic [CW:0]   hi2;
    logic          reset_hit, last_one;

    assign hi2       = {hi_len, 1'b0};
    assign reset_hit = rst_armed && !level && !rise && (low_cnt == CW'(RESET_CYC));
    assign last_one  = prev_ok ? (hi2 >= {1'b0, prev_per})
                               : (hi_len >= CW'(FALLBACK_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            in_bit    <= 1'b0;
            have_fall <= 1'b0;
            rst_armed <= 1'b0;
            prev_ok   <= 1'b0;
            rst_d     <= 1'b0;
            per_cnt   <= '0;
            hi_len    <= '0;
            prev_per  <= '0;
            low_cnt   <= '0;
            evt       <= '0;
            frame_rst <= 1'b0;
        end else begin
            evt       <= '0;
            rst_d     <= reset_hit;
            frame_rst <= rst_d;

            if (in_bit && per_cnt != CMAX)
                per_cnt <= per_cnt + 1'b1;

            if (rise) begin
                if (in_bit && have_fall) begin
                    evt      <= '{valid: 1'b1, value: (hi2 > {1'b0, per_cnt})};
                    prev_per <= per_cnt;
                    prev_ok  <= 1'b1;
                end
                in_bit    <= 1'b1;
                have_fall <= 1'b0;
                per_cnt   <= CW'(1);
                rst_armed <= 1'b0;
            end else if (in_bit && per_cnt == CMAX) begin
                in_bit    <= 1'b0;
                have_fall <= 1'b0;
            end

            if (fall) begin
                rst_armed <= 1'b1;
                low_cnt   <= CW'(1);
                if (in_bit && !have_fall) begin
                    hi_len    <= per_cnt;
                    have_fall <= 1'b1;
                end
            end else if (!level && low_cnt != CMAX) begin
                low_cnt <= low_cnt + 1'b1;
            end

            if (reset_hit) begin
                rst_armed <= 1'b0;
                if (in_bit && have_fall)
                    evt <= '{valid: 1'b1, value: last_one};
                in_bit    <= 1'b0;
                have_fall <= 1'b0;
                prev_ok   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pxd_pixel_pack.sv
module pxd_pixel_pack
    import pxd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  px_mode_e        mode,
    input  bit_evt_t        evt,
    input  logic            frame_rst,
    output logic [PX_W-1:0] pixel,
    output logic            pixel_valid
);
    logic [PX_W-1:0] acc;
    logic [5:0]      cnt;
    logic [PX_W-1:0] nxt;

    assign nxt = {acc[PX_W-2:0], evt.value};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc         <= '0;
            cnt         <= '0;
            pixel       <= '0;
            pixel_valid <= 1'b0;
        end else begin
            pixel_valid <= 1'b0;
            if (frame_rst) begin
                acc <= '0;
                cnt <= '0;
            end else if (evt.valid) begin
                if (6'(cnt + 6'd1) >= px_need(mode)) begin
                    pixel       <= px_reorder(nxt, mode);
                    pixel_valid <= 1'b1;
                    acc         <= '0;
                    cnt         <= '0;
                end else begin
                    acc <= nxt;
                    cnt <= cnt + 6'd1;
                end
            end
        end
    end
endmodule

// File: rtl/pixel_stream_decoder.sv
module pixel_stream_decoder
    import pxd_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int RESET_NS = 50_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        din,
    input  logic        mode,
    output logic [31:0] pixel_data,
    output logic        pixel_valid,
    output logic        frame_reset,
    output logic        bit_valid,
    output logic        bit_value
);
    localparam int RESET_CYC    = int'((longint'(CLK_HZ) * RESET_NS) / 1_000_000_000);
    localparam int FALLBACK_CYC = int'((longint'(CLK_HZ) * 625) / 1_000_000_000);
    localparam int CW           = $clog2(RESET_CYC + 2) + 1;

    logic     level, rise, fall, frame_rst;
    bit_evt_t evt;

    pxd_line_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .level (level),
        .rise  (rise),
        .fall  (fall)
    );

    pxd_bit_timer #(
        .CW           (CW),
        .RESET_CYC    (RESET_CYC),
        .FALLBACK_CYC (FALLBACK_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .level     (level),
        .rise      (rise),
        .fall      (fall),
        .evt       (evt),
        .frame_rst (frame_rst)
    );

    pxd_pixel_pack u_pack (
        .clk         (clk),
        .rst         (rst),
        .mode        (px_mode_e'(mode)),
        .evt         (evt),
        .frame_rst   (frame_rst),
        .pixel       (pixel_data),
        .pixel_valid (pixel_valid)
    );

    assign frame_reset = frame_rst;
    assign bit_valid   = evt.valid;
    assign bit_value   = evt.value;
endmodule

// File: rtl/pxd_checker.sv
module pxd_checker (
    input logic        clk,
    input logic        rst,
    input logic        din,
    input logic        mode,
    input logic [31:0] pixel_data,
    input logic        pixel_valid,
    input logic        frame_reset,
    input logic        bit_valid
);
    logic seen_low;

    always_ff @(posedge clk) begin
        if (rst)       seen_low <= 1'b0;
        else if (!din) seen_low <= 1'b1;
    end

    a_r8_pixel_after_bit: assert property (@(posedge clk) disable iff (rst)
        pixel_valid |-> $past(bit_valid));

    a_r4_no_bit_with_reset: assert property (@(posedge clk) disable iff (rst)
        frame_reset |-> !bit_valid);

    a_r4_reset_single_cycle: assert property (@(posedge clk) disable iff (rst)
        frame_reset |=> !frame_reset);

    a_r6_rgb_top_byte_zero: assert property (@(posedge clk) disable iff (rst)
        (pixel_valid && !mode) |-> (pixel_data[31:24] == 8'h00));

    a_r5_no_bit_before_low: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> seen_low);

    a_r1_bit_single_cycle: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);
endmodule

bind pixel_stream_decoder pxd_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .mode        (mode),
    .pixel_data  (pixel_data),
    .pixel_valid (pixel_valid),
    .frame_reset (frame_reset),
    .bit_valid   (bit_valid)
);

// File: tb/tb_pixel_stream_decoder.sv
`timescale 1ns/1ps
module tb_pixel_stream_decoder;
    localparam int CLK_HZ   = 100_000_000;
    localparam int RESET_NS = 50_000;
    localparam int RC       = 5000;   // RESET_NS at 100 MHz

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        din = 1'b1;
    logic        mode = 1'b0;
    logic [31:0] pixel_data;
    logic        pixel_valid, frame_reset, bit_valid, bit_value;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    logic        bitq[$];
    logic [31:0] pixq[$];
    int          rst_cnt = 0;
    longint      cyc = 0, last_bit_cyc = -10, last_rst_cyc = -10;

    always #5 clk = ~clk;

    pixel_stream_decoder #(.CLK_HZ(CLK_HZ), .RESET_NS(RESET_NS)) dut (
        .clk(clk), .rst(rst), .din(din), .mode(mode),
        .pixel_data(pixel_data), .pixel_valid(pixel_valid),
        .frame_reset(frame_reset), .bit_valid(bit_valid), .bit_value(bit_value)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (bit_valid)   begin bitq.push_back(bit_value); last_bit_cyc <= cyc; end
            if (pixel_valid) pixq.push_back(pixel_data);
            if (frame_reset) begin rst_cnt <= rst_cnt + 1; last_rst_cyc <= cyc; end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic send_bit(input int hi, input int per);
        din = 1'b1; step(hi);
        din = 1'b0; step(per - hi);
    endtask

    task automatic send_word(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            if (w[i]) send_bit(80, 125); else send_bit(35, 125);
        end
    endtask

    task automatic clear_obs();
        bitq.delete(); pixq.delete();
    endtask

    task automatic wait_reset(input string req, output int waited);
        int start;
        start = rst_cnt; waited = 0; din = 1'b0;
        while (rst_cnt == start && waited < RC + 300) begin step(1); waited++; end
        check(rst_cnt == start + 1, req, rst_cnt - start, 1);
        check(last_rst_cyc == last_bit_cyc + 1 || bitq.size() == 0, "R4 reset follows final bit",
              last_rst_cyc - last_bit_cyc, 1);
    endtask

    task automatic t_reset_state();
        int w;
        rst = 1'b1; din = 1'b1; step(5); rst = 1'b0;
        check({pixel_valid, frame_reset, bit_valid, bit_value, pixel_data} == '0, "R5 reset outputs", pixel_data, 0);
        step(300);
        check(bitq.size() == 0 && rst_cnt == 0, "R5 high line idle", bitq.size() + rst_cnt, 0);
        wait_reset("R4 first low reset", w);
        check(w >= RC && w <= RC + 8, "R4 reset latency", w, RC + 4);
    endtask

    task automatic t_rgb();
        int w;
        clear_obs(); mode = 1'b0;
        send_word(32'h123456, 24);
        wait_reset("R4 rgb frame", w);
        check(bitq.size() == 24, "R1 bit count", bitq.size(), 24);
        check(pixq.size() == 1, "R6 pixel count", pixq.size(), 1);
        if (pixq.size() > 0) check(pixq[0] == 32'h00341256, "R6 rgb reorder", pixq[0], 32'h00341256);
    endtask

    task automatic t_two_pixels();
        int w;
        clear_obs(); mode = 1'b0;
        send_word(32'hFF0000, 24);
        send_word(32'h00FF00, 24);
        wait_reset("R4 two pixel frame", w);
        check(pixq.size() == 2, "R8 pixel count", pixq.size(), 2);
        if (pixq.size() == 2) begin
            check(pixq[0] == 32'h0000FF00, "R8 first pixel", pixq[0], 32'h0000FF00);
            check(pixq[1] == 32'h00FF0000, "R8 second pixel", pixq[1], 32'h00FF0000);
        end
    endtask

    task automatic t_rgbw();
        int w;
        clear_obs(); mode = 1'b1;
        send_word(32'hA1B2C3D4, 32);
        wait_reset("R4 rgbw frame", w);
        check(pixq.size() == 1, "R7 pixel count", pixq.size(), 1);
        if (pixq.size() > 0) check(pixq[0] == 32'hA1C3B2D4, "R7 rgbw reorder", pixq[0], 32'hA1C3B2D4);
        mode = 1'b0;
    endtask

    task automatic t_partial();
        int w;
        clear_obs(); mode = 1'b0;
        send_word(32'h3FF, 10);
        wait_reset("R4 partial frame", w);
        check(pixq.size() == 0 && bitq.size() == 10, "R4 partial dropped", pixq.size(), 0);
        clear_obs();
        send_word(32'h112233, 24);
        wait_reset("R4 after partial", w);
        check(pixq.size() == 1, "R4 pixel after partial", pixq.size(), 1);
        if (pixq.size() > 0) check(pixq[0] == 32'h00221133, "R4 clean accumulator", pixq[0], 32'h00221133);
    endtask

    task automatic t_threshold();
        int w;
        logic [4:0] got;
        clear_obs();
        send_bit(60, 120); send_bit(61, 120); send_bit(40, 100); send_bit(51, 100); send_bit(35, 125);
        wait_reset("R4 threshold frame", w);
        got = '0;
        for (int i = 0; i < 5 && i < bitq.size(); i++) got[4 - i] = bitq[i];
        check(bitq.size() == 5 && got == 5'b01010, "R1 half period boundary", got, 5'b01010);
    endtask

    task automatic t_last_prev();
        int w;
        clear_obs();
        send_bit(35, 125); send_bit(63, 125);
        wait_reset("R2 frame a", w);
        check(bitq.size() == 2 && bitq[1] == 1'b1, "R2 final 63 of 125", bitq.size() == 2 ? bitq[1] : 2, 1);
        clear_obs();
        send_bit(35, 125); send_bit(62, 125);
        wait_reset("R2 frame b", w);
        check(bitq.size() == 2 && bitq[1] == 1'b0, "R2 final 62 of 125", bitq.size() == 2 ? bitq[1] : 2, 0);
    endtask

    task automatic t_fallback();
        int w;
        clear_obs();
        send_bit(62, 125);
        wait_reset("R3 frame a", w);
        check(bitq.size() == 1 && bitq[0] == 1'b1, "R3 lone bit 62", bitq.size() == 1 ? bitq[0] : 2, 1);
        clear_obs();
        send_bit(61, 125);
        wait_reset("R3 frame b", w);
        check(bitq.size() == 1 && bitq[0] == 1'b0, "R3 lone bit 61", bitq.size() == 1 ? bitq[0] : 2, 0);
    endtask

    task automatic t_stuck_high();
        int w;
        clear_obs(); mode = 1'b0;
        din = 1'b1; step(17000);
        din = 1'b0; step(100);
        send_word(32'h445566, 24);
        wait_reset("R9 frame", w);
        check(bitq.size() == 24, "R9 long high dropped", bitq.size(), 24);
        if (pixq.size() > 0) check(pixq[0] == 32'h00554466, "R9 pixel after stuck", pixq[0], 32'h00554466);
        else check(1'b0, "R9 pixel after stuck", 0, 32'h00554466);
    endtask

    initial begin
        t_reset_state();
        t_rgb();
        t_two_pixels();
        t_rgbw();
        t_partial();
        t_threshold();
        t_last_prev();
        t_fallback();
        t_stuck_high();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule